// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts return targets for a branch predictor front end. It keeps a fixed number of return addresses in a ring of entries. A top-of-stack pointer selects the current entry. A call pushes its return address and a return pops one. When the ring fills up, further pushes wrap around and overwrite the oldest address instead of stalling.

The fetch stage reads the current top address and the pointer index every cycle. It saves the index alongside each prediction. After a misprediction it issues a restore command with that saved index and the correct target. The pointer jumps back to the saved index, and the entry at that index is rewritten with the target. A count of valid entries is kept next to the pointer, and an empty flag tells the consumer when the top address carries no meaning.

Each cycle a command arbiter reduces the three request lines to one operation: OP_HOLD, OP_POP, OP_PUSH or OP_RESTORE. The pointer controller then takes the transition named by that operation.
- HOLD keeps all state.
- PUSH advances the pointer and writes.
- POP retreats the pointer.
- RESTORE loads the pointer and writes.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous reset sets the top index to 0 and the valid count to 0, and asserts empty. Entry contents are left as they are.
- R2: A push advances the top index by one. The pushed address is written at the new index, so it appears on the top address output after the clock edge. The valid count rises by one.
- R3: A push from index ENTRIES-1 wraps the pointer to index 0. The valid count saturates at ENTRIES, and further pushes overwrite the oldest entries.
- R4: A pop moves the top index back by one and lowers a nonzero valid count by one. The top address then shows the entry pushed before.
- R5: A pop from index 0 moves the pointer to ENTRIES-1. A pop with a valid count of 0 still moves the pointer, and the count stays 0.
- R6: A restore loads the top index with the supplied index and writes the supplied address into that entry. The valid count is unchanged.
- R7: Restore has priority over push, and push over pop. When several requests are raised together, only the winning operation changes the pointer, the count and the storage.
- R8: The empty output is high exactly when the valid count is 0.
- R9: The top address output shows, without a clock delay, the entry selected by the current top index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| push_addr_i | input | AW | Return address to push |
| pop_i | input | 1 | Pop request |
| restore_i | input | 1 | Restore request after a misprediction |
| restore_idx_i | input | PW | Saved pointer index to return to |
| restore_addr_i | input | AW | Target written at the restored index |
| top_addr_o | output | AW | Entry at the current top index |
| top_idx_o | output | PW | Current top index, to be saved by the caller |
| valid_cnt_o | output | CW | Number of valid entries, 0 to ENTRIES |
| empty_o | output | 1 | High when the valid count is 0 |

## Verification
Push and pop, or a restore together with both, can be requested in the same cycle. The bench raises push and pop together and expects a plain push: the index advances, the new address is on top, and the count rises with no decrement. It then raises all three requests while a known value sits in the slot a push would have written. It checks that the pointer lands on the restore index with the restore address and an unchanged count. Finally it pops back onto that slot to show that the losing push address never reached storage.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // One operation per cycle, chosen by the command arbiter.
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_POP     = 2'd1,
        OP_PUSH    = 2'd2,
        OP_RESTORE = 2'd3
    } ras_op_e;

endpackage

// File: rtl/ras_cmd_arb.sv
module ras_cmd_arb
    import ras_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    restore_i,
    output ras_op_e op_o
);

    // Fixed priority: restore, then push, then pop.
    always_comb begin
        if (restore_i)
            op_o = OP_RESTORE;
        else if (push_i)
            op_o = OP_PUSH;
        else if (pop_i)
            op_o = OP_POP;
        else
            op_o = OP_HOLD;
    end

endmodule

// File: rtl/ras_ptr_ctl.sv
module ras_ptr_ctl
    import ras_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW = $clog2(ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  ras_op_e       op_i,
    input  logic [PW-1:0] restore_idx_i,
    output logic [PW-1:0] tos_o,
    output logic [CW-1:0] cnt_o,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o
);

    localparam logic [PW-1:0] LAST_IDX = PW'(ENTRIES - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(ENTRIES);

    logic [PW-1:0] tos_q, tos_d, tos_inc, tos_dec;
    logic [CW-1:0] cnt_q, cnt_d;

    assign tos_inc = (tos_q == LAST_IDX) ? '0 : tos_q + 1'b1;
    assign tos_dec = (tos_q == '0) ? LAST_IDX : tos_q - 1'b1;

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            cnt_q <= '0;
        end else begin
            tos_q <= tos_d;
            cnt_q <= cnt_d;
        end
    end

    // Transition process
    always_comb begin
        tos_d    = tos_q;
        cnt_d    = cnt_q;
        wr_en_o  = 1'b0;
        wr_idx_o = tos_inc;
        unique case (op_i)
            OP_HOLD: ;
            OP_PUSH: begin
                tos_d    = tos_inc;
                cnt_d    = (cnt_q == FULL_CNT) ? cnt_q : cnt_q + 1'b1;
                wr_en_o  = 1'b1;
                wr_idx_o = tos_inc;
            end
            OP_POP: begin
                tos_d = tos_dec;
                cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            end
            OP_RESTORE: begin
                tos_d    = restore_idx_i;
                wr_en_o  = 1'b1;
                wr_idx_o = restore_idx_i;
            end
            default: ;
        endcase
    end

    // Output process
    always_comb begin
        tos_o = tos_q;
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int ENTRIES = 8,
    parameter int AW = 32,
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);

    logic [AW-1:0] mem_q [ENTRIES];

    // One register per entry; no reset on contents.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PW'(g)))
                mem_q[g] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int AW = 32,
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW = $clog2(ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    input  logic          restore_i,
    input  logic [PW-1:0] restore_idx_i,
    input  logic [AW-1:0] restore_addr_i,
    output logic [AW-1:0] top_addr_o,
    output logic [PW-1:0] top_idx_o,
    output logic [CW-1:0] valid_cnt_o,
    output logic          empty_o
);

    ras_op_e       op;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [AW-1:0] wr_data;
    logic [PW-1:0] tos;
    logic [CW-1:0] cnt;

    ras_cmd_arb u_arb (
        .push_i    (push_i),
        .pop_i     (pop_i),
        .restore_i (restore_i),
        .op_o      (op)
    );

    ras_ptr_ctl #(.ENTRIES(ENTRIES)) u_ptr (
        .clk           (clk),
        .rst           (rst),
        .op_i          (op),
        .restore_idx_i (restore_idx_i),
        .tos_o         (tos),
        .cnt_o         (cnt),
        .wr_en_o       (wr_en),
        .wr_idx_o      (wr_idx)
    );

    assign wr_data = (op == OP_RESTORE) ? restore_addr_i : push_addr_i;

    ras_store #(.ENTRIES(ENTRIES), .AW(AW)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (tos),
        .rd_data_o (top_addr_o)
    );

    assign top_idx_o   = tos;
    assign valid_cnt_o = cnt;
    assign empty_o     = (cnt == '0);

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
    parameter int ENTRIES = 8,
    parameter int AW = 32,
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW = $clog2(ENTRIES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push_i,
    input logic [AW-1:0] push_addr_i,
    input logic          pop_i,
    input logic          restore_i,
    input logic [PW-1:0] restore_idx_i,
    input logic [AW-1:0] restore_addr_i,
    input logic [AW-1:0] top_addr_o,
    input logic [PW-1:0] top_idx_o,
    input logic [CW-1:0] valid_cnt_o,
    input logic          empty_o
);

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] i);
        return (i == PW'(ENTRIES - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [PW-1:0] prv(input logic [PW-1:0] i);
        return (i == '0) ? PW'(ENTRIES - 1) : i - 1'b1;
    endfunction

    logic do_push, do_pop;
    assign do_push = push_i && !restore_i;
    assign do_pop  = pop_i && !push_i && !restore_i;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (top_idx_o == '0) && (valid_cnt_o == '0) && empty_o);

    a_r2_push_top: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(do_push)) |->
            (top_idx_o == nxt($past(top_idx_o))) && (top_addr_o == $past(push_addr_i)));

    a_r3_count_sat: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(do_push) && ($past(valid_cnt_o) == CW'(ENTRIES)))
            |-> valid_cnt_o == CW'(ENTRIES));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        valid_cnt_o <= CW'(ENTRIES));

    a_r4_pop_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(do_pop) && ($past(valid_cnt_o) != '0)) |->
            (top_idx_o == prv($past(top_idx_o))) && (valid_cnt_o == $past(valid_cnt_o) - 1'b1));

    a_r5_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(do_pop) && ($past(valid_cnt_o) == '0)) |->
            (top_idx_o == prv($past(top_idx_o))) && (valid_cnt_o == '0));

    a_r6_restore: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(restore_i)) |->
            (top_idx_o == $past(restore_idx_i)) && (top_addr_o == $past(restore_addr_i))
            && (valid_cnt_o == $past(valid_cnt_o)));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(push_i) && !$past(pop_i) && !$past(restore_i)) |->
            $stable(top_idx_o) && $stable(valid_cnt_o) && $stable(top_addr_o));

    a_r8_empty: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(do_push)) |-> !empty_o);

endmodule

bind ret_addr_stack ret_addr_stack_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .push_i         (push_i),
    .push_addr_i    (push_addr_i),
    .pop_i          (pop_i),
    .restore_i      (restore_i),
    .restore_idx_i  (restore_idx_i),
    .restore_addr_i (restore_addr_i),
    .top_addr_o     (top_addr_o),
    .top_idx_o      (top_idx_o),
    .valid_cnt_o    (valid_cnt_o),
    .empty_o        (empty_o)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 8;
    localparam int AW = 32;
    localparam int PW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic          pop_i = 1'b0;
    logic          restore_i = 1'b0;
    logic [PW-1:0] restore_idx_i = '0;
    logic [AW-1:0] restore_addr_i = '0;
    logic [AW-1:0] top_addr_o;
    logic [PW-1:0] top_idx_o;
    logic [CW-1:0] valid_cnt_o;
    logic          empty_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ret_addr_stack #(.ENTRIES(ENTRIES), .AW(AW)) dut (
        .clk            (clk),
        .rst            (rst),
        .push_i         (push_i),
        .push_addr_i    (push_addr_i),
        .pop_i          (pop_i),
        .restore_i      (restore_i),
        .restore_idx_i  (restore_idx_i),
        .restore_addr_i (restore_addr_i),
        .top_addr_o     (top_addr_o),
        .top_idx_o      (top_idx_o),
        .valid_cnt_o    (valid_cnt_o),
        .empty_o        (empty_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply the given requests for one edge, then sample 1 time unit later.
    task automatic cycle(input logic pu, input logic [AW-1:0] pa, input logic po,
                         input logic re, input logic [PW-1:0] ri, input logic [AW-1:0] ra);
        push_i = pu; push_addr_i = pa; pop_i = po;
        restore_i = re; restore_idx_i = ri; restore_addr_i = ra;
        @(posedge clk);
        #1;
        push_i = 1'b0; pop_i = 1'b0; restore_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic state(input string req, input int idx, input int cnt,
                         input logic [AW-1:0] top);
        chk(req, "top_idx", 64'(top_idx_o), 64'(idx));
        chk(req, "valid_cnt", 64'(valid_cnt_o), 64'(cnt));
        chk(req, "top_addr", 64'(top_addr_o), 64'(top));
        chk("R8", "empty", 64'(empty_o), 64'(cnt == 0));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "top_idx", 64'(top_idx_o), 64'd0);
        chk("R1", "valid_cnt", 64'(valid_cnt_o), 64'd0);
        chk("R1", "empty", 64'(empty_o), 64'd1);
    endtask

    task automatic t_push_pop();
        do_reset();
        for (int i = 1; i <= 3; i++) begin
            cycle(1'b1, 32'hA000_0000 + AW'(i), 1'b0, 1'b0, '0, '0);
            state("R2", i, i, 32'hA000_0000 + AW'(i));
        end
        cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
        state("R4", 2, 2, 32'hA000_0002);
        // R9: output follows the pointer within the same cycle
        cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
        state("R9", 1, 1, 32'hA000_0001);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 1; i <= 9; i++) begin
            cycle(1'b1, 32'hB000_0000 + AW'(i), 1'b0, 1'b0, '0, '0);
            state("R3", i % ENTRIES, (i < ENTRIES) ? i : ENTRIES, 32'hB000_0000 + AW'(i));
        end
        cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
        state("R3", 0, 7, 32'hB000_0008);
        cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
        state("R5", 7, 6, 32'hB000_0007);
    endtask

    task automatic t_underflow();
        do_reset();
        cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
        chk("R5", "top_idx", 64'(top_idx_o), 64'(ENTRIES - 1));
        chk("R5", "valid_cnt", 64'(valid_cnt_o), 64'd0);
        chk("R5", "empty", 64'(empty_o), 64'd1);
    endtask

    task automatic t_restore();
        do_reset();
        for (int i = 1; i <= 3; i++)
            cycle(1'b1, 32'hC000_0000 + AW'(i), 1'b0, 1'b0, '0, '0);
        cycle(1'b0, '0, 1'b0, 1'b1, 3'd1, 32'hDEAD_0001);
        state("R6", 1, 3, 32'hDEAD_0001);
        cycle(1'b1, 32'hC000_0009, 1'b0, 1'b0, '0, '0);
        state("R6", 2, 4, 32'hC000_0009);
    endtask

    task automatic t_priority();
        do_reset();
        cycle(1'b0, '0, 1'b0, 1'b1, 3'd3, 32'h0000_0333);
        cycle(1'b0, '0, 1'b0, 1'b1, 3'd2, 32'h0000_0222);
        state("R6", 2, 0, 32'h0000_0222);
        // all three at once: restore wins; the push slot (3) keeps its value
        cycle(1'b1, 32'hBAD0_0000, 1'b1, 1'b1, 3'd5, 32'h0000_0555);
        state("R7", 5, 0, 32'h0000_0555);
        cycle(1'b0, '0, 1'b0, 1'b1, 3'd4, 32'h0000_0444);
        cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
        state("R7", 3, 0, 32'h0000_0333);
        // push and pop together: push wins, count rises
        cycle(1'b1, 32'h0000_0777, 1'b1, 1'b0, '0, '0);
        state("R7", 4, 1, 32'h0000_0777);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_push_pop();
        t_wrap();
        t_underflow();
        t_restore();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule